// File: doc/BRIEF.md
# Programmable NVM Access Clock Generator

This block divides the fast system clock down to the clock that strobes a non-volatile memory array. A 6-bit period field sets the divider. The generated clock period is the field value plus one, counted in system clock cycles. A field value of zero is not a legal divisor, so the block substitutes fifteen for it. The clock is the output of a flip-flop, so it cannot glitch. Whenever it stops, it stops in its low phase.

The access sequencer drives a request level. In the default gated mode, the clock is idle and low until a request arrives. It then runs for one period per access and stops again once no request is pending at the end of a period. In continuous mode, the clock runs all the time, and an access waits for the next period boundary. In suppress mode, an access that is still requested when the current access reaches its falling edge is chained to it: the clock stays high across the join, so the two accesses show no edge between them. A one-cycle done strobe marks the last system cycle of every access period.

Top module: `nvm_aclk_gen`

## Requirements
- R1: After reset, `aclk` and `acc_done` are low. In gated mode with no request, `aclk` stays low, and every stop of the clock leaves it low.
- R2: For a period field c in 1..63, rising edges of a running `aclk` are c+1 system cycles apart, and the high phase lasts floor((c+1)/2) cycles.
- R3: A period field of 0 gives a period of 16 cycles with an 8-cycle high phase.
- R4: In gated mode with the clock idle, a request sampled at a clock edge makes `aclk` high after that edge. A request that is high at the last cycle of an access period starts the next access with no idle cycle.
- R5: In continuous mode, `aclk` runs with no request and `acc_done` stays low. A request starts an access only at the next period boundary.
- R6: With suppress set, if the request is still high when the current access reaches the end of its high phase, `aclk` stays high across the rest of that period and into the next access. Back-to-back accesses then form one unbroken high level.
- R7: `acc_done` is high for exactly one cycle, the last cycle of each access period. Outside a suppressed chain, `aclk` is low in that cycle.
- R8: A change of the period field takes effect only from the next period boundary. The period in progress keeps its length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| period_cfg | input | PW | Divider field; period = value+1 cycles, 0 means 15 |
| cont_mode | input | 1 | 1: free-running clock |
| suppress_mode | input | 1 | 1: join back-to-back accesses without an edge |
| acc_req | input | 1 | Access request level from the sequencer |
| aclk | output | 1 | Generated memory access clock |
| acc_done | output | 1 | One-cycle strobe in the final cycle of an access period |

## Verification
The bench builds the block with its default parameters: a 6-bit period field and a zero substitute of 15. Both the largest divisor of 64 cycles and the zero fallback are therefore exercised. Random runs draw the field mostly from small values, so that many periods, mode changes and chained accesses fit into the run. Directed cases measure the periods at 1, 5, 63 and 0, and a change made in the middle of a period.

// File: rtl/nvm_aclk_gen.sv
module nvm_aclk_gen #(
  parameter int PW       = 6,
  parameter int ZERO_SUB = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] period_cfg,
  input  logic          cont_mode,
  input  logic          suppress_mode,
  input  logic          acc_req,
  output logic          aclk,
  output logic          acc_done
);
  localparam logic [PW-1:0] SUB = PW'(ZERO_SUB);

  function automatic logic [PW-1:0] half_of(input logic [PW-1:0] e);
    logic [PW:0] p;
    p = {1'b0, e} + 1'b1;
    return p[PW:1];
  endfunction

  logic          run_q, acc_q, chain_q, aclk_q, done_q;
  logic [PW-1:0] cnt_q, eff_q;
  logic          run_n, acc_n, chain_n;
  logic [PW-1:0] cnt_n, eff_n, eff_in;
  logic          at_end;

  assign eff_in   = (period_cfg == '0) ? SUB : period_cfg;
  assign at_end   = (cnt_q == eff_q);
  assign aclk     = aclk_q;
  assign acc_done = done_q;

  always_comb begin
    run_n   = run_q;
    cnt_n   = cnt_q;
    eff_n   = eff_q;
    acc_n   = acc_q;
    chain_n = chain_q;
    if (!run_q) begin
      if (cont_mode || acc_req) begin
        run_n   = 1'b1;
        cnt_n   = '0;
        eff_n   = eff_in;
        acc_n   = acc_req;
        chain_n = 1'b0;
      end
    end else if (at_end) begin
      acc_n   = chain_q || acc_req;
      run_n   = cont_mode || acc_n;
      cnt_n   = '0;
      eff_n   = eff_in;
      chain_n = 1'b0;
    end else begin
      cnt_n = cnt_q + 1'b1;
      if (acc_q && suppress_mode && acc_req && cnt_n == half_of(eff_q))
        chain_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      cnt_q   <= '0;
      eff_q   <= SUB;
      acc_q   <= 1'b0;
      chain_q <= 1'b0;
      aclk_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      run_q   <= run_n;
      cnt_q   <= cnt_n;
      eff_q   <= eff_n;
      acc_q   <= acc_n;
      chain_q <= chain_n;
      aclk_q  <= run_n && ((cnt_n < half_of(eff_n)) || chain_n);
      done_q  <= run_n && acc_n && (cnt_n == eff_n);
    end
  end
endmodule

// File: rtl/nvm_aclk_gen_chk.sv
module nvm_aclk_gen_chk #(
  parameter int PW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_req,
  input logic          aclk,
  input logic          acc_done,
  input logic          run_q,
  input logic          chain_q,
  input logic [PW-1:0] cnt_q,
  input logic [PW-1:0] eff_q
);
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !aclk); // R1
  AST_EFF_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    eff_q != '0); // R3
  AST_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && acc_req) |=> aclk); // R4
  AST_CHAIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    chain_q |-> aclk); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |=> !acc_done); // R7
  AST_DONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_done && !chain_q) |-> !aclk); // R7
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= eff_q); // R8
endmodule

bind nvm_aclk_gen nvm_aclk_gen_chk #(.PW(PW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .acc_req  (acc_req),
  .aclk     (aclk),
  .acc_done (acc_done),
  .run_q    (run_q),
  .chain_q  (chain_q),
  .cnt_q    (cnt_q),
  .eff_q    (eff_q)
);

// File: tb/nvm_aclk_gen_bench.sv
module nvm_aclk_gen_bench;
  localparam int PW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [PW-1:0] period_cfg = '0;
  logic          cont_mode = 1'b0;
  logic          suppress_mode = 1'b0;
  logic          acc_req = 1'b0;
  logic          aclk, acc_done;

  int checks = 0;
  int errors = 0;
  bit cmp_en = 1'b0;

  always #4 clk = ~clk;

  nvm_aclk_gen u_nvm_aclk_gen (
    .clk(clk), .rst_n(rst_n), .period_cfg(period_cfg), .cont_mode(cont_mode),
    .suppress_mode(suppress_mode), .acc_req(acc_req), .aclk(aclk), .acc_done(acc_done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  bit m_live, m_serve, m_stretch, m_aclk, m_done;
  int m_pos, m_len;

  function automatic int want_len(input logic [PW-1:0] c);
    return (c == 0) ? 16 : int'(c) + 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_live = 0; m_serve = 0; m_stretch = 0; m_pos = 0; m_len = 16;
      m_aclk = 0; m_done = 0;
    end else begin
      if (!m_live) begin
        if (cont_mode || acc_req) begin
          m_live = 1; m_pos = 0; m_len = want_len(period_cfg);
          m_serve = acc_req; m_stretch = 0;
        end
      end else if (m_pos == m_len - 1) begin
        m_serve = m_stretch || acc_req;
        m_live = cont_mode || m_serve;
        m_pos = 0; m_len = want_len(period_cfg); m_stretch = 0;
      end else begin
        m_pos++;
        if (m_serve && suppress_mode && acc_req && m_pos == m_len / 2) m_stretch = 1;
      end
      m_aclk = m_live && (m_pos < m_len / 2 || m_stretch);
      m_done = m_live && m_serve && (m_pos == m_len - 1);
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      check(acc_done == m_done, "R7", int'(acc_done), int'(m_done));
      check(aclk == m_aclk, suppress_mode ? "R6" : (cont_mode ? "R5" : "R4"),
            int'(aclk), int'(m_aclk));
    end
  end

  task automatic wait_rise();
    logic p;
    p = aclk;
    forever begin
      @(negedge clk);
      if (aclk && !p) break;
      p = aclk;
    end
  endtask

  task automatic measure(output int per, output int hi);
    logic p;
    wait_rise();
    per = 0; hi = 1; p = 1'b1;
    forever begin
      @(negedge clk);
      per++;
      if (aclk && !p) break;
      if (aclk) hi++;
      p = aclk;
    end
  endtask

  task automatic go_idle();
    cont_mode = 0; acc_req = 0; suppress_mode = 0;
    repeat (70) @(negedge clk);
  endtask

  task automatic period_case(input logic [PW-1:0] c, input string tag);
    int per, hi, exp;
    period_cfg = c;
    wait_rise(); wait_rise();
    measure(per, hi);
    exp = want_len(c);
    check(per == exp, tag, per, exp);
    check(hi == exp / 2, tag, hi, exp / 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n, lows, dones, rises;
    logic p;
    void'($urandom(32'd7319));
    repeat (4) begin
      @(negedge clk);
      check(aclk == 0 && acc_done == 0, "R1", int'(aclk), 0);
    end
    rst_n = 1;
    cmp_en = 1;

    lows = 0;
    repeat (20) begin @(negedge clk); if (aclk) lows++; end
    check(lows == 0, "R1", lows, 0);

    cont_mode = 1;
    period_case(6'd5, "R2");
    period_case(6'd1, "R2");
    period_case(6'd63, "R2");
    period_case(6'd0, "R3");

    // R8: change in the middle of a 10-cycle period
    period_cfg = 6'd9;
    wait_rise(); wait_rise();
    n = 0; p = 1'b1;
    forever begin
      @(negedge clk);
      n++;
      if (n == 2) period_cfg = 6'd3;
      if (aclk && !p) break;
      p = aclk;
    end
    check(n == 10, "R8", n, 10);
    begin
      int per, hi;
      measure(per, hi);
      check(per == 4, "R8", per, 4);
    end

    // R5: free-running without requests
    period_cfg = 6'd2;
    rises = 0; dones = 0; p = aclk;
    repeat (30) begin
      @(negedge clk);
      if (aclk && !p) rises++;
      if (acc_done) dones++;
      p = aclk;
    end
    check(rises >= 9, "R5", rises, 10);
    check(dones == 0, "R5", dones, 0);

    // R4 and R7: single gated access
    go_idle();
    period_cfg = 6'd4;
    acc_req = 1;
    @(negedge clk);
    check(aclk == 1, "R4", int'(aclk), 1);
    acc_req = 0;
    dones = 0; lows = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (acc_done) begin
        dones++;
        check(aclk == 0, "R7", int'(aclk), 0);
      end
      if (i >= 10 && aclk) lows++;
    end
    check(dones == 1, "R7", dones, 1);
    check(lows == 0, "R1", lows, 0);

    // R6: chained accesses under suppress
    go_idle();
    period_cfg = 6'd3;
    suppress_mode = 1;
    acc_req = 1;
    lows = 0; dones = 0;
    repeat (16) begin
      @(negedge clk);
      if (!aclk) lows++;
      if (acc_done) dones++;
    end
    check(lows == 0, "R6", lows, 0);
    check(dones == 4, "R6", dones, 4);
    acc_req = 0;
    repeat (20) @(negedge clk);
    check(aclk == 0, "R1", int'(aclk), 0);

    // R4: same stream without suppress shows low phases, back-to-back
    suppress_mode = 0;
    acc_req = 1;
    lows = 0; dones = 0;
    repeat (16) begin
      @(negedge clk);
      if (!aclk) lows++;
      if (acc_done) dones++;
    end
    check(lows == 8, "R4", lows, 8);
    check(dones == 4, "R4", dones, 4);
    acc_req = 0;

    // random phase, compared cycle by cycle against the bench model
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if ($urandom % 4 == 0) acc_req = ~acc_req;
      if ($urandom % 200 == 0) cont_mode = ~cont_mode;
      if ($urandom % 150 == 0) suppress_mode = ~suppress_mode;
      if ($urandom % 300 == 0)
        period_cfg = ($urandom % 5 == 0) ? PW'($urandom % 64) : PW'($urandom % 8);
    end

    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule